// File: doc/BRIEF.md
# Chained Diversity Data Link

This block carries per-carrier soft OFDM words between demodulators wired in a chain. Each device can take one of four roles: standalone, head of the chain, middle link or tail. The head sends its own channel-corrected words downstream. Middle and tail devices capture the words arriving from upstream, hold them in a small alignment queue, and merge them carrier by carrier with their own local words. For each carrier the merge keeps the word with the better quality tag. A middle device sends the merged stream on to the next device. The tail device, like a standalone one, only delivers its result locally.

The link has a 5-bit word bus, a separate valid strobe and a forwarded clock at the sample-clock rate. The receiver latches the word and the strobe on the rising edge of the incoming link clock. A configuration input inverts the forwarded clock, so that its rising edge falls in the middle of each data cell. A symbol-start pulse empties the alignment queue, so that carrier pairing starts again cleanly at each symbol.

Top module: `divlink_top`

## Requirements
- R1: During and right after reset, out_valid, tx_valid and tx_data are all 0.
- R2: A word is {quality tag in bits 4:3, soft payload in bits 2:0}. In role MID (2) or LAST (3), when a stored link word is waiting and its tag is strictly greater than the local word's tag, out_data is the link word. It appears one clock after the local word is presented.
- R3: If the stored link word's tag equals or is lower than the local tag, out_data is the local word.
- R4: If no link word is stored when a local word arrives, the local word is passed through unchanged, one clock later, with out_valid high.
- R5: A word on rx_data with rx_valid low is not stored, and it never reaches out_data.
- R6: A sym_start pulse discards every stored link word. Local words that follow it pass through unchanged until new link words arrive.
- R7: In role FIRST (1), incoming link words are ignored. out_data and tx_data both carry the local word, one clock later, with tx_valid high.
- R8: In roles NONE (0) and LAST (3), tx_valid and tx_data stay 0 and tx_clk stays low. The merged result still appears on out_valid and out_data.
- R9: In role MID, tx_valid and tx_data carry the same merged word as out_valid and out_data, in the same cycle.
- R10: In roles FIRST and MID, tx_clk follows clk when cfg_clk_inv is 0 and is its complement when cfg_clk_inv is 1.
- R11: Stored link words are consumed in arrival order, one per local word.
- R12: A link word is latched on a rising rx_clk edge. It can be paired with any local word presented at or after the second rising clk edge that follows its capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_role | input | 2 | Chain role: 0 none, 1 first, 2 middle, 3 last |
| cfg_clk_inv | input | 1 | Invert the forwarded link clock |
| sym_start | input | 1 | Symbol-start pulse; empties the alignment queue |
| loc_valid | input | 1 | Local word strobe |
| loc_data | input | 5 | Local word {tag, payload} |
| rx_clk | input | 1 | Incoming link clock |
| rx_valid | input | 1 | Incoming link strobe |
| rx_data | input | 5 | Incoming link word |
| out_valid | output | 1 | Merged word strobe |
| out_data | output | 5 | Merged word |
| tx_clk | output | 1 | Forwarded link clock |
| tx_valid | output | 1 | Outgoing link strobe |
| tx_data | output | 5 | Outgoing link word |

## Verification
A local word presented before a rising edge shows up on the merged and transmit outputs after that same edge. The bench drives every input just after a falling edge and samples at the next falling edge. Each link word is pushed at least two rising edges before the local word it pairs with, because one edge captures it and a second one stores it. A symbol-start pulse takes effect at the edge that samples it. The forwarded clock is sampled a quarter period after each clk edge, in both phases.

// File: rtl/divlink_pkg.sv
package divlink_pkg;
   typedef enum logic [1:0] {
      ROLE_NONE  = 2'd0,
      ROLE_FIRST = 2'd1,
      ROLE_MID   = 2'd2,
      ROLE_LAST  = 2'd3
   } role_e;

   function automatic logic role_merges(input role_e r);
      return (r == ROLE_MID) || (r == ROLE_LAST);
   endfunction

   function automatic logic role_sends(input role_e r);
      return (r == ROLE_FIRST) || (r == ROLE_MID);
   endfunction
endpackage

// File: rtl/divlink_rx_capture.sv
module divlink_rx_capture #(
   parameter int DATA_W = 5
) (
   input  logic              rx_clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              cap_valid,
   output logic [DATA_W-1:0] cap_data
);
   always_ff @(posedge rx_clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_data  <= '0;
      end else begin
         cap_valid <= rx_valid;
         cap_data  <= rx_valid ? rx_data : '0;
      end
   end
endmodule

// File: rtl/divlink_align_fifo.sv
module divlink_align_fifo #(
   parameter int DATA_W = 5,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic              head_ok,
   output logic [DATA_W-1:0] head_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("divlink_align_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic [CNT_W-1:0]  cnt;
   logic              do_push, do_pop;

   assign head_ok   = (cnt != '0);
   assign head_data = mem[rptr];
   assign do_push   = push && !clr && (cnt != CNT_W'(DEPTH));
   assign do_pop    = pop && !clr && head_ok;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 mem[gi] <= '0;
            else if (do_push && wptr == PTR_W'(gi))     mem[gi] <= din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   AST_SYNC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !head_ok); // R6
   AST_INVALID_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop && !clr) |=> $stable(cnt)); // R5
   AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && head_ok && !push && !clr) |=> (cnt == $past(cnt) - 1'b1)); // R11
endmodule

// File: rtl/divlink_select.sv
module divlink_select #(
   parameter int DATA_W = 5,
   parameter int TAG_W  = 2
) (
   input  logic [DATA_W-1:0] loc_data,
   input  logic              link_ok,
   input  logic [DATA_W-1:0] link_data,
   output logic [DATA_W-1:0] sel_data
);
   localparam int TAG_LSB = DATA_W - TAG_W;

   generate
      if (TAG_W < 1 || TAG_W >= DATA_W) begin : g_bad_tag
         $error("divlink_select: TAG_W must be in 1..DATA_W-1");
      end
   endgenerate

   logic [TAG_W-1:0] loc_tag, link_tag;
   assign loc_tag  = loc_data[DATA_W-1:TAG_LSB];
   assign link_tag = link_data[DATA_W-1:TAG_LSB];

   always_comb begin
      if (link_ok && (link_tag > loc_tag)) sel_data = link_data;
      else                                 sel_data = loc_data;
   end
endmodule

// File: rtl/divlink_out_stage.sv
module divlink_out_stage #(
   parameter int DATA_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_en,
   input  logic              clk_inv,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              tx_clk,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         tx_valid  <= 1'b0;
         tx_data   <= '0;
      end else begin
         out_valid <= in_valid;
         out_data  <= in_valid ? in_data : '0;
         tx_valid  <= in_valid && send_en;
         tx_data   <= (in_valid && send_en) ? in_data : '0;
      end
   end

   assign tx_clk = send_en ? (clk ^ clk_inv) : 1'b0;
endmodule

// File: rtl/divlink_top.sv
module divlink_top #(
   parameter int DATA_W     = 5,
   parameter int TAG_W      = 2,
   parameter int FIFO_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_role,
   input  logic              cfg_clk_inv,
   input  logic              sym_start,
   input  logic              loc_valid,
   input  logic [DATA_W-1:0] loc_data,
   input  logic              rx_clk,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              tx_clk,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data
);
   import divlink_pkg::*;

   localparam int TAG_LSB = DATA_W - TAG_W;

   role_e             role;
   logic              merging, sending;
   logic              cap_valid;
   logic [DATA_W-1:0] cap_data;
   logic              head_ok;
   logic [DATA_W-1:0] head_data;
   logic [DATA_W-1:0] sel_data;

   assign role    = role_e'(cfg_role);
   assign merging = role_merges(role);
   assign sending = role_sends(role);

   divlink_rx_capture #(.DATA_W(DATA_W)) u_cap (
      .rx_clk(rx_clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .cap_valid(cap_valid), .cap_data(cap_data)
   );

   divlink_align_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(sym_start),
      .push(cap_valid && merging), .din(cap_data),
      .pop(loc_valid && merging),
      .head_ok(head_ok), .head_data(head_data)
   );

   divlink_select #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel (
      .loc_data(loc_data), .link_ok(head_ok && merging && !sym_start),
      .link_data(head_data), .sel_data(sel_data)
   );

   divlink_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .send_en(sending), .clk_inv(cfg_clk_inv),
      .in_valid(loc_valid), .in_data(sel_data),
      .out_valid(out_valid), .out_data(out_data),
      .tx_clk(tx_clk), .tx_valid(tx_valid), .tx_data(tx_data)
   );

   AST_OUT_FOLLOWS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      loc_valid |=> out_valid); // R4
   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_valid |=> !out_valid); // R5
   AST_TIE_KEEPS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && merging && head_ok && !sym_start &&
       head_data[DATA_W-1:TAG_LSB] <= loc_data[DATA_W-1:TAG_LSB])
      |=> (out_data == $past(loc_data))); // R3
   AST_FIRST_SENDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && role == ROLE_FIRST) |=> (tx_valid && tx_data == $past(loc_data))); // R7
   AST_IDLE_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sending && $past(!sending)) |-> (!tx_valid && !tx_clk)); // R8
   AST_MID_TX_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (role == ROLE_MID && $past(role == ROLE_MID)) |-> (tx_data == out_data)); // R9
endmodule

// File: tb/divlink_top_bench.sv
module divlink_top_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_role = 2'd0;
   logic       cfg_clk_inv = 1'b0;
   logic       sym_start = 1'b0;
   logic       loc_valid = 1'b0;
   logic [4:0] loc_data = '0;
   logic       rx_clk;
   logic       rx_valid = 1'b0;
   logic [4:0] rx_data = '0;
   logic       out_valid, tx_clk, tx_valid;
   logic [4:0] out_data, tx_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign rx_clk = clk;

   divlink_top u_divlink_top (
      .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role), .cfg_clk_inv(cfg_clk_inv),
      .sym_start(sym_start), .loc_valid(loc_valid), .loc_data(loc_data),
      .rx_clk(rx_clk), .rx_valid(rx_valid), .rx_data(rx_data),
      .out_valid(out_valid), .out_data(out_data),
      .tx_clk(tx_clk), .tx_valid(tx_valid), .tx_data(tx_data)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic pulse_sync();
      @(negedge clk); sym_start = 1'b1;
      @(negedge clk); sym_start = 1'b0;
   endtask

   task automatic push_link(input logic [4:0] d, input logic v);
      @(negedge clk); rx_valid = v; rx_data = d;
      @(negedge clk); rx_valid = 1'b0; rx_data = '0;
   endtask

   // present a local word; outputs are due after the next rising edge
   task automatic send_local(input logic [4:0] d, input logic [4:0] exp, input string req);
      bit sends;
      sends = (cfg_role == 2'd1) || (cfg_role == 2'd2);
      @(negedge clk); loc_valid = 1'b1; loc_data = d;
      @(negedge clk); loc_valid = 1'b0; loc_data = '0;
      check({req, " out_valid"}, out_valid, 1);
      check({req, " out_data"}, out_data, exp);
      check({req, " tx_valid"}, tx_valid, sends ? 1 : 0);
      check({req, " tx_data"}, tx_data, sends ? exp : 0);
   endtask

   task automatic check_txclk(input string req);
      bit sends;
      sends = (cfg_role == 2'd1) || (cfg_role == 2'd2);
      @(posedge clk); #(CLK_PERIOD/4);
      check({req, " tx_clk high phase"}, tx_clk, sends ? (1 ^ cfg_clk_inv) : 0);
      @(negedge clk); #(CLK_PERIOD/4);
      check({req, " tx_clk low phase"}, tx_clk, sends ? (0 ^ cfg_clk_inv) : 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 out_valid", out_valid, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R1 tx_data", tx_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after release", out_valid, 0);

      // R2 R3 R9 R12: full tag sweep in role MID
      cfg_role = 2'd2;
      for (int lt = 0; lt < 4; lt++) begin
         for (int ct = 0; ct < 4; ct++) begin
            logic [4:0] lw, cw;
            lw = {2'(lt), 3'(lt + 2 * ct + 1)};
            cw = {2'(ct), 3'(ct + 5)};
            pulse_sync();
            push_link(lw, 1'b1);
            send_local(cw, (lt > ct) ? lw : cw, (lt > ct) ? "R2 R9 R12 mid" : "R3 R9 mid");
         end
      end

      // R2 R3 R8 sweep in role LAST
      cfg_role = 2'd3;
      for (int lt = 0; lt < 4; lt++) begin
         for (int ct = 0; ct < 4; ct += 3) begin
            logic [4:0] lw, cw;
            lw = {2'(lt), 3'(7 - lt)};
            cw = {2'(ct), 3'(ct)};
            pulse_sync();
            push_link(lw, 1'b1);
            send_local(cw, (lt > ct) ? lw : cw, (lt > ct) ? "R2 R8 last" : "R3 R8 last");
         end
      end
      check_txclk("R8 last");

      // R4 no link word stored
      pulse_sync();
      send_local(5'b00011, 5'b00011, "R4 empty");
      send_local(5'b10110, 5'b10110, "R4 empty");

      // R5 word without strobe is not stored
      pulse_sync();
      push_link(5'b11111, 1'b0);
      send_local(5'b00001, 5'b00001, "R5 invalid ignored");

      // R6 sym_start discards stored words
      pulse_sync();
      push_link(5'b11010, 1'b1);
      push_link(5'b11011, 1'b1);
      pulse_sync();
      send_local(5'b00100, 5'b00100, "R6 cleared");
      send_local(5'b01100, 5'b01100, "R6 cleared");

      // R11 arrival order, then queue exhausted
      cfg_role = 2'd2;
      pulse_sync();
      for (int k = 1; k <= 3; k++) push_link({2'b11, 3'(k)}, 1'b1);
      for (int k = 1; k <= 3; k++) send_local(5'b00000, {2'b11, 3'(k)}, "R11 order");
      send_local(5'b01010, 5'b01010, "R11 R4 drained");

      // R10 clock forwarding, both polarities
      cfg_clk_inv = 1'b0;
      check_txclk("R10 plain");
      cfg_clk_inv = 1'b1;
      check_txclk("R10 inverted");

      // R7 role FIRST ignores the link
      cfg_role = 2'd1;
      pulse_sync();
      push_link(5'b11111, 1'b1);
      send_local(5'b00010, 5'b00010, "R7 first");
      send_local(5'b10101, 5'b10101, "R7 first");
      check_txclk("R7 R10 first");

      // R8 role NONE keeps link idle
      cfg_role = 2'd0;
      cfg_clk_inv = 1'b0;
      pulse_sync();
      push_link(5'b11111, 1'b1);
      send_local(5'b01001, 5'b01001, "R8 none");
      check_txclk("R8 none");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule